// File: doc/BRIEF.md
# DMA Channel Service Arbiter

This block decides which of a parameterised set of DMA channels the transfer engine services next. Every channel presents a request, formed either from a level hardware request qualified by a per-channel enable or from a one-shot software start that names the channel by number. Each channel also carries a priority value, a flag that lets it be suspended by a more urgent channel, and a flag that stops it from suspending others. The arbiter issues a registered grant index with a valid flag. It emits a one-cycle suspend pulse when it interrupts the running channel, and it reports priority values that collide.

Two arbitration modes are selected by a global input. In fixed-priority mode the highest priority value wins, and an eligible higher-priority requester may interrupt a running channel. The interrupted channel gets the grant back once the interrupting channel reports completion. In round-robin mode priorities and preemption are disregarded and requesters are served in ascending rotation after the last granted channel. A debug stall input holds off new channel starts while letting the active channel run to completion.

The control is a four-state machine. ST_IDLE (no grant) moves to ST_RUN when a winner exists and the stall is low. ST_RUN returns to ST_IDLE on completion, or moves to ST_NESTED on preemption, saving the running channel. ST_NESTED moves to ST_RESUME on completion. ST_RESUME (no grant, one cycle) goes back to ST_RUN with the saved channel, or to ST_NESTED if a new requester outranks the saved channel.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, grant_valid, suspend_pulse and prio_err are all low, and the round-robin pointer is the highest channel index, so the first rotation starts at channel 0.
- R2: A channel requests when (hw_req AND hw_req_en) is set for it, or when a pulse on sw_start with sw_start_ch equal to its index has been latched. A hardware request whose enable is low is ignored. A latched software start is cleared when that channel is granted.
- R3: In fixed-priority mode (rr_mode = 0), from idle, the arbiter grants the requester with the numerically largest priority, with ties going to the lower index. A request present at a clock edge is reflected in grant_idx and grant_valid right after that edge.
- R4: While a channel is granted, grant_idx stays constant unless a preemption occurs. A ch_done pulse ends the grant, grant_valid is low for at least one cycle, and then the next winner is granted.
- R5: In fixed-priority mode, if the running channel has ch_preemptible set and some requester has a strictly larger priority with ch_no_preempt clear, that requester is granted at the next edge. suspend_pulse is high for exactly that one cycle, together with grant_valid.
- R6: No preemption occurs when the running channel's ch_preemptible is clear, when the requester's ch_no_preempt is set, or when the requester's priority is not larger than the running channel's.
- R7: When a preempting channel completes, grant_valid is low for one cycle. Then the suspended channel is granted again, ahead of any requester whose priority is not larger than its own.
- R8: In round-robin mode (rr_mode = 1), priorities and preemption flags are ignored, suspend_pulse never fires, and the grant goes to the first requesting channel above the last granted index, wrapping to 0.
- R9: In fixed-priority mode, prio_err is high from the edge after any two channels hold the same priority value. In round-robin mode it is low.
- R10: While dbg_halt is high, no channel is started from idle and no preemption occurs. A channel that is already granted keeps its grant and may complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rr_mode | input | 1 | 1 = round-robin, 0 = fixed priority |
| dbg_halt | input | 1 | Stall new channel starts |
| hw_req | input | NUM_CH | Level hardware requests |
| hw_req_en | input | NUM_CH | Per-channel hardware request enable |
| sw_start | input | 1 | One-cycle software start pulse |
| sw_start_ch | input | IDX_W | Channel addressed by sw_start |
| ch_prio | input | NUM_CH*PRIO_W | Packed priorities, channel i at bits [i*PRIO_W +: PRIO_W] |
| ch_preemptible | input | NUM_CH | Channel may be suspended |
| ch_no_preempt | input | NUM_CH | Channel may not suspend others |
| ch_done | input | 1 | Active channel finished (one-cycle pulse) |
| grant_idx | output | IDX_W | Granted channel |
| grant_valid | output | 1 | A channel is granted |
| suspend_pulse | output | 1 | One-cycle marker of a preemption |
| prio_err | output | 1 | Duplicate priority in fixed mode |

## Verification
The bench builds the arbiter with NUM_CH = 8 and PRIO_W = 3. With these values the eight channels can hold eight unique priorities, and giving a single channel a second channel's value brings the duplicate-priority flag into reach. The round-robin pointer wraps after a few grants, so rotation past the top index is exercised within a short vector table. The narrow configuration also makes preemption, resume ordering and debug stalls easy to arrange with a handful of channels at hand-picked priorities.

// File: rtl/dca_pkg.sv
package dca_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_NESTED = 2'd2,
        ST_RESUME = 2'd3
    } dca_state_e;

endpackage

// File: rtl/dca_req_gate.sv
module dca_req_gate #(
    parameter int NUM_CH = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hw_req,
    input  logic [NUM_CH-1:0] hw_req_en,
    input  logic              sw_start,
    input  logic [IDX_W-1:0]  sw_start_ch,
    input  logic              take,
    input  logic [IDX_W-1:0]  take_idx,
    output logic [NUM_CH-1:0] req_vec
);

    logic [NUM_CH-1:0] sw_pend;

    // One latch per channel for software starts (R2)
    for (genvar i = 0; i < NUM_CH; i++) begin : g_pend
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sw_pend[i] <= 1'b0;
            end else if (sw_start && (sw_start_ch == IDX_W'(i))) begin
                sw_pend[i] <= 1'b1;
            end else if (take && (take_idx == IDX_W'(i))) begin
                sw_pend[i] <= 1'b0;
            end
        end
    end

    assign req_vec = (hw_req & hw_req_en) | sw_pend;

endmodule

// File: rtl/dca_prio_select.sv
module dca_prio_select #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic [NUM_CH-1:0]        req_vec,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    output logic                     found,
    output logic [IDX_W-1:0]         pick_idx,
    output logic [PRIO_W-1:0]        pick_prio
);

    // Largest value wins; strict compare keeps the lower index on a tie
    always_comb begin
        found     = 1'b0;
        pick_idx  = '0;
        pick_prio = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req_vec[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] > pick_prio))) begin
                found     = 1'b1;
                pick_idx  = IDX_W'(i);
                pick_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/dca_rr_select.sv
module dca_rr_select #(
    parameter int NUM_CH = 16,
    parameter int IDX_W  = 4
) (
    input  logic [NUM_CH-1:0] req_vec,
    input  logic [IDX_W-1:0]  last_idx,
    output logic              found,
    output logic [IDX_W-1:0]  pick_idx
);

    localparam int CW = IDX_W + 1;

    always_comb begin : blk_scan
        logic [CW-1:0] cand;
        found    = 1'b0;
        pick_idx = last_idx;
        for (int k = 1; k <= NUM_CH; k++) begin
            cand = {1'b0, last_idx} + CW'(k);
            if (cand >= CW'(NUM_CH)) begin
                cand = cand - CW'(NUM_CH);
            end
            if (!found && req_vec[cand[IDX_W-1:0]]) begin
                found    = 1'b1;
                pick_idx = cand[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dca_dup_detect.sv
module dca_dup_detect #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4
) (
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    output logic                     dup
);

    localparam int PAIRS = NUM_CH * NUM_CH;

    logic [PAIRS-1:0] pair_eq;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_row
        for (genvar j = 0; j < NUM_CH; j++) begin : g_col
            if (j > i) begin : g_cmp
                assign pair_eq[i*NUM_CH+j] =
                    (prio_flat[i*PRIO_W +: PRIO_W] == prio_flat[j*PRIO_W +: PRIO_W]);
            end else begin : g_nil
                assign pair_eq[i*NUM_CH+j] = 1'b0;
            end
        end
    end

    assign dup = |pair_eq;

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dca_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rr_mode,
    input  logic                     dbg_halt,
    input  logic [NUM_CH-1:0]        hw_req,
    input  logic [NUM_CH-1:0]        hw_req_en,
    input  logic                     sw_start,
    input  logic [IDX_W-1:0]         sw_start_ch,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
    input  logic [NUM_CH-1:0]        ch_preemptible,
    input  logic [NUM_CH-1:0]        ch_no_preempt,
    input  logic                     ch_done,
    output logic [IDX_W-1:0]         grant_idx,
    output logic                     grant_valid,
    output logic                     suspend_pulse,
    output logic                     prio_err
);

    dca_state_e state_q, state_d;

    logic [IDX_W-1:0] grant_q, grant_d;
    logic [IDX_W-1:0] susp_q, susp_d;
    logic [IDX_W-1:0] last_q, last_d;
    logic             pulse_q, pulse_d;
    logic             err_q;

    logic             take;
    logic [IDX_W-1:0] take_idx;

    logic [NUM_CH-1:0] req_vec;
    logic [NUM_CH-1:0] excl_vec;
    logic [NUM_CH-1:0] cand_vec;
    logic [NUM_CH-1:0] pre_vec;

    logic              pk_found, pe_found, rr_found, dup_found;
    logic [IDX_W-1:0]  pk_idx, pe_idx, rr_idx;
    logic [PRIO_W-1:0] pk_prio, pe_prio;
    logic [PRIO_W-1:0] act_prio, susp_prio;
    logic              preempt_ok;

    // ---------------------------------------------------------------
    // Request formation
    // ---------------------------------------------------------------
    dca_req_gate #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_req      (hw_req),
        .hw_req_en   (hw_req_en),
        .sw_start    (sw_start),
        .sw_start_ch (sw_start_ch),
        .take        (take),
        .take_idx    (take_idx),
        .req_vec     (req_vec)
    );

    // The channel already owning (or holding) the grant is not a candidate
    always_comb begin
        excl_vec = '0;
        unique case (state_q)
            ST_RUN, ST_NESTED: excl_vec[grant_q] = 1'b1;
            ST_RESUME:         excl_vec[susp_q]  = 1'b1;
            default:           excl_vec = '0;
        endcase
    end

    assign cand_vec = req_vec & ~excl_vec;
    assign pre_vec  = cand_vec & ~ch_no_preempt;

    // ---------------------------------------------------------------
    // Selectors: general winner and preemption candidate
    // ---------------------------------------------------------------
    dca_prio_select #(
        .NUM_CH (NUM_CH),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_pick_main (
        .req_vec   (cand_vec),
        .prio_flat (ch_prio),
        .found     (pk_found),
        .pick_idx  (pk_idx),
        .pick_prio (pk_prio)
    );

    dca_prio_select #(
        .NUM_CH (NUM_CH),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_pick_pre (
        .req_vec   (pre_vec),
        .prio_flat (ch_prio),
        .found     (pe_found),
        .pick_idx  (pe_idx),
        .pick_prio (pe_prio)
    );

    dca_rr_select #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_pick_rr (
        .req_vec  (cand_vec),
        .last_idx (last_q),
        .found    (rr_found),
        .pick_idx (rr_idx)
    );

    dca_dup_detect #(
        .NUM_CH (NUM_CH),
        .PRIO_W (PRIO_W)
    ) u_dup (
        .prio_flat (ch_prio),
        .dup       (dup_found)
    );

    assign act_prio  = ch_prio[int'(grant_q)*PRIO_W +: PRIO_W];
    assign susp_prio = ch_prio[int'(susp_q)*PRIO_W +: PRIO_W];

    assign preempt_ok = !rr_mode && !dbg_halt && ch_preemptible[grant_q]
                        && pe_found && (pe_prio > act_prio);

    // ---------------------------------------------------------------
    // Next-state and next-output logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d  = state_q;
        grant_d  = grant_q;
        susp_d   = susp_q;
        last_d   = last_q;
        pulse_d  = 1'b0;
        take     = 1'b0;
        take_idx = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (!dbg_halt) begin
                    if (rr_mode && rr_found) begin
                        state_d  = ST_RUN;
                        grant_d  = rr_idx;
                        last_d   = rr_idx;
                        take     = 1'b1;
                        take_idx = rr_idx;
                    end else if (!rr_mode && pk_found) begin
                        state_d  = ST_RUN;
                        grant_d  = pk_idx;
                        last_d   = pk_idx;
                        take     = 1'b1;
                        take_idx = pk_idx;
                    end
                end
            end
            ST_RUN: begin
                if (ch_done) begin
                    state_d = ST_IDLE;
                end else if (preempt_ok) begin
                    state_d  = ST_NESTED;
                    susp_d   = grant_q;
                    grant_d  = pe_idx;
                    last_d   = pe_idx;
                    pulse_d  = 1'b1;
                    take     = 1'b1;
                    take_idx = pe_idx;
                end
            end
            ST_NESTED: begin
                if (ch_done) begin
                    state_d = ST_RESUME;
                end
            end
            ST_RESUME: begin
                if (!dbg_halt && !rr_mode && pk_found && (pk_prio > susp_prio)) begin
                    state_d  = ST_NESTED;
                    grant_d  = pk_idx;
                    last_d   = pk_idx;
                    take     = 1'b1;
                    take_idx = pk_idx;
                end else begin
                    state_d = ST_RUN;
                    grant_d = susp_q;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
            susp_q  <= '0;
            last_q  <= IDX_W'(NUM_CH - 1);
            pulse_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            grant_q <= grant_d;
            susp_q  <= susp_d;
            last_q  <= last_d;
            pulse_q <= pulse_d;
            err_q   <= !rr_mode && dup_found;
        end
    end

    assign grant_idx     = grant_q;
    assign grant_valid   = (state_q == ST_RUN) || (state_q == ST_NESTED);
    assign suspend_pulse = pulse_q;
    assign prio_err      = err_q;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_pulse |=> !suspend_pulse); // R5

    AST_PULSE_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_pulse |-> grant_valid); // R5

    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(grant_valid) && !suspend_pulse) |-> (grant_idx == $past(grant_idx))); // R4

    AST_RR_NO_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_pulse |-> !$past(rr_mode)); // R8

    AST_RR_PICK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rr_found |-> cand_vec[rr_idx]); // R8

    AST_PICK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pk_found |-> req_vec[pk_idx]); // R3

    AST_ERR_RR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rr_mode) |-> !prio_err); // R9

    AST_DEBUG_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && dbg_halt) |=> !grant_valid); // R10

endmodule

// File: tb/tb_dma_chan_arbiter.sv
module tb_dma_chan_arbiter;

    localparam int NCH = 8;
    localparam int PW  = 3;
    localparam int IW  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rr_mode = 1'b0;
    logic            dbg_halt = 1'b0;
    logic [NCH-1:0]  hw_req = '0;
    logic [NCH-1:0]  hw_req_en = '1;
    logic            sw_start = 1'b0;
    logic [IW-1:0]   sw_start_ch = '0;
    logic [NCH*PW-1:0] ch_prio = '0;
    logic [NCH-1:0]  ch_preemptible = '0;
    logic [NCH-1:0]  ch_no_preempt = '0;
    logic            ch_done = 1'b0;
    logic [IW-1:0]   grant_idx;
    logic            grant_valid;
    logic            suspend_pulse;
    logic            prio_err;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dma_chan_arbiter #(
        .NUM_CH (NCH),
        .PRIO_W (PW)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rr_mode        (rr_mode),
        .dbg_halt       (dbg_halt),
        .hw_req         (hw_req),
        .hw_req_en      (hw_req_en),
        .sw_start       (sw_start),
        .sw_start_ch    (sw_start_ch),
        .ch_prio        (ch_prio),
        .ch_preemptible (ch_preemptible),
        .ch_no_preempt  (ch_no_preempt),
        .ch_done        (ch_done),
        .grant_idx      (grant_idx),
        .grant_valid    (grant_valid),
        .suspend_pulse  (suspend_pulse),
        .prio_err       (prio_err)
    );

    // {rr_mode, request mask, expected grant}; priority of channel i is (3*i) mod 8
    localparam logic [11:0] VEC [12] = '{
        {1'b0, 8'h01, 3'd0},
        {1'b0, 8'h06, 3'd2},
        {1'b0, 8'hFF, 3'd5},
        {1'b0, 8'h90, 3'd7},
        {1'b0, 8'h48, 3'd6},
        {1'b1, 8'hFF, 3'd7},
        {1'b1, 8'hFF, 3'd0},
        {1'b1, 8'h05, 3'd2},
        {1'b1, 8'h05, 3'd0},
        {1'b1, 8'h20, 3'd5},
        {1'b1, 8'h21, 3'd0},
        {1'b1, 8'h08, 3'd3}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_ch(input int c);
        hw_req[c] = 1'b1;
        step();
        hw_req[c] = 1'b0;
    endtask

    task automatic finish_ch();
        ch_done = 1'b1;
        step();
        ch_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) ch_prio[i*PW +: PW] = PW'((3 * i) % 8);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk(!grant_valid, "R1 grant_valid", grant_valid, 0);
        chk(!suspend_pulse, "R1 suspend_pulse", suspend_pulse, 0);
        chk(!prio_err, "R1 prio_err", prio_err, 0);

        // Vector table: R3 fixed priority, R8 rotation
        for (int v = 0; v < 12; v++) begin
            rr_mode = VEC[v][11];
            hw_req  = VEC[v][10:3];
            step();
            chk(grant_valid && grant_idx == VEC[v][2:0],
                VEC[v][11] ? "R8 rotation grant" : "R3 priority grant",
                grant_idx, VEC[v][2:0]);
            hw_req = '0;
            finish_ch();
            step();
        end
        rr_mode = 1'b0;

        // R2 disabled hardware request ignored
        hw_req_en[3] = 1'b0;
        hw_req[3] = 1'b1;
        step();
        step();
        chk(!grant_valid, "R2 disabled hw request", grant_valid, 0);
        hw_req[3] = 1'b0;
        hw_req_en[3] = 1'b1;

        // R2 software start, cleared on grant
        sw_start = 1'b1;
        sw_start_ch = 3'd4;
        step();
        sw_start = 1'b0;
        step();
        chk(grant_valid && grant_idx == 3'd4, "R2 sw start grant", grant_idx, 4);
        finish_ch();
        step();
        chk(!grant_valid, "R2 sw start cleared", grant_valid, 0);

        // R6/R4 non-preemptible running channel keeps grant
        start_ch(1);
        hw_req[5] = 1'b1;
        step();
        chk(!suspend_pulse && grant_idx == 3'd1, "R6 not preemptible", grant_idx, 1);
        step();
        chk(grant_valid && grant_idx == 3'd1, "R4 grant held", grant_idx, 1);
        finish_ch();
        chk(!grant_valid, "R4 gap after done", grant_valid, 0);
        step();
        chk(grant_valid && grant_idx == 3'd5, "R4 next winner", grant_idx, 5);
        hw_req[5] = 1'b0;
        finish_ch();
        step();

        // R5/R7 preemption and resume
        ch_preemptible[1] = 1'b1;
        start_ch(1);
        hw_req[6] = 1'b1;
        step();
        chk(!suspend_pulse && grant_idx == 3'd1, "R6 lower prio no preempt", grant_idx, 1);
        hw_req[5] = 1'b1;
        step();
        chk(suspend_pulse && grant_valid && grant_idx == 3'd5, "R5 preempt grant", grant_idx, 5);
        hw_req[5] = 1'b0;
        step();
        chk(!suspend_pulse && grant_idx == 3'd5, "R5 pulse one cycle", suspend_pulse, 0);
        finish_ch();
        chk(!grant_valid, "R7 resume gap", grant_valid, 0);
        step();
        chk(grant_valid && grant_idx == 3'd1, "R7 resume suspended", grant_idx, 1);
        finish_ch();
        step();
        chk(grant_valid && grant_idx == 3'd6, "R3 waiting channel", grant_idx, 6);
        hw_req[6] = 1'b0;
        finish_ch();
        step();

        // R6 requester barred from preempting
        start_ch(1);
        ch_no_preempt[5] = 1'b1;
        hw_req[5] = 1'b1;
        step();
        chk(!suspend_pulse && grant_idx == 3'd1, "R6 no_preempt set", grant_idx, 1);
        hw_req[5] = 1'b0;
        ch_no_preempt[5] = 1'b0;
        ch_preemptible[1] = 1'b0;
        finish_ch();
        step();

        // R10 debug stall
        ch_preemptible[2] = 1'b1;
        dbg_halt = 1'b1;
        hw_req[2] = 1'b1;
        step();
        step();
        chk(!grant_valid, "R10 no start in debug", grant_valid, 0);
        dbg_halt = 1'b0;
        step();
        chk(grant_valid && grant_idx == 3'd2, "R10 start after debug", grant_idx, 2);
        hw_req[2] = 1'b0;
        dbg_halt = 1'b1;
        hw_req[5] = 1'b1;
        step();
        chk(grant_valid && !suspend_pulse && grant_idx == 3'd2, "R10 no preempt in debug", grant_idx, 2);
        hw_req[5] = 1'b0;
        finish_ch();
        chk(!grant_valid, "R10 completes in debug", grant_valid, 0);
        dbg_halt = 1'b0;
        ch_preemptible[2] = 1'b0;
        step();

        // R9 duplicate priority
        ch_prio[7*PW +: PW] = 3'd3;
        step();
        chk(prio_err, "R9 duplicate flagged", prio_err, 1);
        rr_mode = 1'b1;
        step();
        chk(!prio_err, "R9 low in rr mode", prio_err, 0);
        rr_mode = 1'b0;
        ch_prio[7*PW +: PW] = 3'd5;
        step();
        chk(!prio_err, "R9 cleared when unique", prio_err, 0);

        // R8 round-robin ignores preemption
        rr_mode = 1'b1;
        ch_preemptible[0] = 1'b1;
        start_ch(0);
        hw_req[5] = 1'b1;
        step();
        chk(grant_idx == 3'd0 && !suspend_pulse, "R8 no preempt in rr", grant_idx, 0);
        hw_req[5] = 1'b0;
        finish_ch();
        step();
        rr_mode = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule